// File: doc/BRIEF.md
# Wrapper Serial Path Router

This block sits inside a core test wrapper and decides which register lies between the wrapper's serial test input and its serial test output. It owns a single bypass flip-flop on the wrapper clock. It also wires the boundary chain ahead of the core's internal scan chains, so that together they form one long chain when the internal-scan test mode is active.

Two multiplexer stages form the output. The first stage takes a binary path-select code from the instruction decoder. Code 0 selects the bypass flip-flop. Code 1 selects the boundary chain alone, which serves the boundary-only internal test and the external test. Code 2 selects the boundary chain followed by the scan chains. Codes 3 and up select the other data registers in index order. Any code above the last data register falls back to the bypass flip-flop, so a serial path always exists. The second stage hands the output to the instruction register whenever the instruction-register select input is high.

The boundary cells, the scan chains, the instruction register and the other data registers lie outside this block. They reach it through their serial inputs and outputs.

Top module: `wsp_router`

## Requirements
- R1: The active-low reset `rst_n` clears the bypass flip-flop asynchronously. While reset is low, and with code 0 selected and `sel_ir` low, `so` reads 0 without waiting for a clock edge.
- R2: On a rising `clk` edge with `shift_en` high and `sel_ir` low, the bypass flip-flop captures `si`. With code 0 selected, `so` then shows that bit until the next edge.
- R3: With `shift_en` low, the bypass flip-flop keeps its value across clock edges whatever `si` does.
- R4: With `sel_ir` high, the bypass flip-flop keeps its value across clock edges even when `shift_en` is high.
- R5: While `sel_ir` is high, `so` equals `ir_so` for every `path_sel` value.
- R6: With `sel_ir` low and `path_sel` = 1, `so` equals `bnd_so`.
- R7: With `path_sel` = 2, the scan chains are spliced behind the boundary chain: `scan_si[0]` = `bnd_so`, `scan_si[i]` = `scan_so[i-1]`, and `so` equals the last chain's `scan_so`.
- R8: With `sel_ir` low and `path_sel` = 3 + k, for k < NUM_DR, `so` equals `dr_so[k]`.
- R9: With `sel_ir` low, any `path_sel` of 3 + NUM_DR or above drives the bypass flip-flop onto `so`.
- R10: `bnd_si` follows `si` in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Wrapper clock |
| rst_n | input | 1 | Asynchronous active-low wrapper reset |
| sel_ir | input | 1 | High: the instruction register drives the serial output |
| shift_en | input | 1 | Shift enable for the serial path |
| path_sel | input | SEL_W | Data-register select code from the instruction decoder |
| si | input | 1 | Wrapper serial input |
| ir_so | input | 1 | Serial output of the instruction register |
| bnd_so | input | 1 | Serial output of the boundary chain |
| scan_so | input | NUM_CHAINS | Serial outputs of the core scan chains |
| dr_so | input | NUM_DR | Serial outputs of the other data registers |
| bnd_si | output | 1 | Serial input feeding the boundary chain |
| scan_si | output | NUM_CHAINS | Serial inputs feeding the core scan chains |
| so | output | 1 | Wrapper serial output |

## Verification
The bench shifts a varied bit pattern through the bypass flip-flop. A stage that were transparent, or that captured one cycle late, would put the wrong bit on `so`. It loads a 1 into the flip-flop and then applies edges with shift disabled, and separately with the instruction register selected. A design that let either condition through would lose the stored 1, and the bench sees this on `so` once the bypass path is chosen again. It drives every code above the last data register. A decoder that let such codes reach a data register, or left the output undriven, would stop showing the bypass bit. It also sets each scan chain's output to a distinct value. A splice that was off by one chain, or that started from the wrong source, would produce mismatched `scan_si` bits and a wrong tail on `so`.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

    // Fixed path-select codes; other data registers start at PATH_DR_BASE
    localparam int PATH_BYPASS   = 0;
    localparam int PATH_BOUNDARY = 1;
    localparam int PATH_SCAN     = 2;
    localparam int PATH_DR_BASE  = 3;

    // Registered state of the bypass stage
    typedef struct packed {
        logic byp;
    } byp_state_t;

endpackage

// File: rtl/wsp_bypass_stage.sv
module wsp_bypass_stage
    import wsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_ok,
    input  logic si,
    output logic byp_q
);

    byp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_ok) begin
            st_d.byp = si;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byp_q = st_q.byp;

endmodule

// File: rtl/wsp_chain_link.sv
module wsp_chain_link #(
    parameter int NUM_CHAINS = 2
) (
    input  logic                  bnd_so,
    input  logic [NUM_CHAINS-1:0] scan_so,
    output logic [NUM_CHAINS-1:0] scan_si,
    output logic                  chain_tail
);

    // Boundary chain heads the spliced chain; each scan chain feeds the next
    for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_link
        if (g == 0) begin : g_head
            assign scan_si[g] = bnd_so;
        end else begin : g_body
            assign scan_si[g] = scan_so[g-1];
        end
    end

    assign chain_tail = scan_so[NUM_CHAINS-1];

endmodule

// File: rtl/wsp_path_mux.sv
module wsp_path_mux
    import wsp_pkg::*;
#(
    parameter int NUM_DR = 2,
    parameter int SEL_W  = 3
) (
    input  logic [SEL_W-1:0]  path_sel,
    input  logic              byp_q,
    input  logic              bnd_so,
    input  logic              chain_tail,
    input  logic [NUM_DR-1:0] dr_so,
    output logic              dr_out
);

    logic pick_d;

    always_comb begin
        pick_d = byp_q;  // bypass is also the fallback for unused codes
        if (path_sel == SEL_W'(PATH_BOUNDARY)) begin
            pick_d = bnd_so;
        end else if (path_sel == SEL_W'(PATH_SCAN)) begin
            pick_d = chain_tail;
        end
        for (int i = 0; i < NUM_DR; i++) begin
            if (int'(path_sel) == PATH_DR_BASE + i) begin
                pick_d = dr_so[i];
            end
        end
    end

    assign dr_out = pick_d;

endmodule

// File: rtl/wsp_router.sv
module wsp_router
    import wsp_pkg::*;
#(
    parameter  int NUM_DR     = 2,
    parameter  int NUM_CHAINS = 2,
    localparam int NUM_CODES  = PATH_DR_BASE + NUM_DR,
    localparam int SEL_W      = $clog2(NUM_CODES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_ir,
    input  logic                  shift_en,
    input  logic [SEL_W-1:0]      path_sel,
    input  logic                  si,
    input  logic                  ir_so,
    input  logic                  bnd_so,
    input  logic [NUM_CHAINS-1:0] scan_so,
    input  logic [NUM_DR-1:0]     dr_so,
    output logic                  bnd_si,
    output logic [NUM_CHAINS-1:0] scan_si,
    output logic                  so
);

    logic byp_bit;
    logic chain_tail;
    logic dr_out;
    logic so_d;

    wsp_bypass_stage u_byp (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_ok (shift_en & ~sel_ir),
        .si       (si),
        .byp_q    (byp_bit)
    );

    wsp_chain_link #(.NUM_CHAINS(NUM_CHAINS)) u_link (
        .bnd_so     (bnd_so),
        .scan_so    (scan_so),
        .scan_si    (scan_si),
        .chain_tail (chain_tail)
    );

    wsp_path_mux #(.NUM_DR(NUM_DR), .SEL_W(SEL_W)) u_mux (
        .path_sel   (path_sel),
        .byp_q      (byp_bit),
        .bnd_so     (bnd_so),
        .chain_tail (chain_tail),
        .dr_so      (dr_so),
        .dr_out     (dr_out)
    );

    // Second stage: instruction register takes the output when selected
    always_comb begin
        so_d = sel_ir ? ir_so : dr_out;
    end

    assign so     = so_d;
    assign bnd_si = si;

endmodule

// File: rtl/wsp_router_chk.sv
module wsp_router_chk #(
    parameter int NUM_DR = 2,
    parameter int SEL_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_ir,
    input logic             shift_en,
    input logic [SEL_W-1:0] path_sel,
    input logic             si,
    input logic             ir_so,
    input logic             bnd_so,
    input logic             so,
    input logic             byp_bit
);

    p_shift_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !sel_ir) |=> (byp_bit == $past(si)));

    p_shift_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(byp_bit));

    p_ir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ir |=> $stable(byp_bit));

    p_ir_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ir |-> (so == ir_so));

    p_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ir && int'(path_sel) == 1) |-> (so == bnd_so));

    p_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ir && int'(path_sel) >= 3 + NUM_DR) |-> (so == byp_bit));

endmodule

bind wsp_router wsp_router_chk #(.NUM_DR(NUM_DR), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_ir   (sel_ir),
    .shift_en (shift_en),
    .path_sel (path_sel),
    .si       (si),
    .ir_so    (ir_so),
    .bnd_so   (bnd_so),
    .so       (so),
    .byp_bit  (byp_bit)
);

// File: tb/tb_wsp_router.sv
`timescale 1ns/1ps
module tb_wsp_router;

    localparam int NUM_DR     = 2;
    localparam int NUM_CHAINS = 2;
    localparam int SEL_W      = $clog2(3 + NUM_DR);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  sel_ir = 1'b0;
    logic                  shift_en = 1'b0;
    logic [SEL_W-1:0]      path_sel = '0;
    logic                  si = 1'b0;
    logic                  ir_so = 1'b0;
    logic                  bnd_so = 1'b0;
    logic [NUM_CHAINS-1:0] scan_so = '0;
    logic [NUM_DR-1:0]     dr_so = '0;
    logic                  bnd_si;
    logic [NUM_CHAINS-1:0] scan_si;
    logic                  so;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wsp_router #(.NUM_DR(NUM_DR), .NUM_CHAINS(NUM_CHAINS)) dut (
        .clk(clk), .rst_n(rst_n), .sel_ir(sel_ir), .shift_en(shift_en),
        .path_sel(path_sel), .si(si), .ir_so(ir_so), .bnd_so(bnd_so),
        .scan_so(scan_so), .dr_so(dr_so), .bnd_si(bnd_si),
        .scan_si(scan_si), .so(so)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // One clock with given si; bypass path shifts when allowed
    task automatic clock_bit(input logic b);
        @(negedge clk);
        si = b;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        path_sel = SEL_W'(0); sel_ir = 0; shift_en = 1;
        clock_bit(1'b1);
        chk(so, 1'b1, "R2 preload");
        @(negedge clk);
        rst_n = 0;
        #1;
        chk(so, 1'b0, "R1 async clear");
        @(negedge clk);
        rst_n = 1;
        shift_en = 0;
        #1;
        chk(so, 1'b0, "R1 after release");
    endtask

    task automatic t_bypass_shift();
        logic [7:0] pat = 8'b1011_0010;
        @(negedge clk);
        path_sel = SEL_W'(0); sel_ir = 0; shift_en = 1;
        for (int i = 0; i < 8; i++) begin
            clock_bit(pat[i]);
            chk(so, pat[i], "R2 shift");
        end
    endtask

    task automatic t_hold();
        @(negedge clk);
        path_sel = SEL_W'(0); sel_ir = 0; shift_en = 1;
        clock_bit(1'b1);
        @(negedge clk);
        shift_en = 0;
        for (int i = 0; i < 3; i++) clock_bit(1'b0);
        chk(so, 1'b1, "R3 hold shift low");
        @(negedge clk);
        sel_ir = 1; shift_en = 1; ir_so = 0;
        for (int i = 0; i < 3; i++) clock_bit(1'b0);
        chk(so, 1'b0, "R5 ir drives so");
        @(negedge clk);
        sel_ir = 0; shift_en = 0;
        #1;
        chk(so, 1'b1, "R4 hold ir selected");
    endtask

    task automatic t_ir();
        @(negedge clk);
        sel_ir = 1; shift_en = 0;
        bnd_so = 0; dr_so = '1; scan_so = '0;
        for (int c = 0; c < (1 << SEL_W); c++) begin
            @(negedge clk);
            path_sel = SEL_W'(c);
            ir_so = c[0];
            #1;
            chk(so, c[0], "R5 ir any code");
            ir_so = ~c[0];
            #1;
            chk(so, ~c[0], "R5 ir toggle");
        end
        sel_ir = 0;
    endtask

    task automatic t_boundary();
        @(negedge clk);
        path_sel = SEL_W'(1); sel_ir = 0; shift_en = 0;
        dr_so = '0; scan_so = '1;
        for (int v = 0; v < 2; v++) begin
            bnd_so = v[0]; si = ~v[0];
            #1;
            chk(so, v[0], "R6 boundary");
            chk(bnd_si, ~v[0], "R10 bnd_si follows si");
        end
    endtask

    task automatic t_scan();
        @(negedge clk);
        path_sel = SEL_W'(2); sel_ir = 0;
        for (int p = 0; p < 8; p++) begin
            bnd_so = p[2];
            scan_so = NUM_CHAINS'(p);
            si = p[0];
            #1;
            chk(scan_si[0], p[2], "R7 head from boundary");
            for (int k = 1; k < NUM_CHAINS; k++)
                chk(scan_si[k], scan_so[k-1], "R7 chain link");
            chk(so, scan_so[NUM_CHAINS-1], "R7 tail on so");
            chk(bnd_si, p[0], "R10 bnd_si in scan");
        end
    endtask

    task automatic t_dr();
        @(negedge clk);
        sel_ir = 0; bnd_so = 1; scan_so = '1;
        for (int k = 0; k < NUM_DR; k++) begin
            path_sel = SEL_W'(3 + k);
            dr_so = NUM_DR'(1) << k;
            #1;
            chk(so, 1'b1, "R8 dr selected high");
            dr_so = ~(NUM_DR'(1) << k);
            #1;
            chk(so, 1'b0, "R8 dr selected low");
        end
    endtask

    task automatic t_unused();
        @(negedge clk);
        path_sel = SEL_W'(0); sel_ir = 0; shift_en = 1;
        clock_bit(1'b1);
        @(negedge clk);
        shift_en = 0;
        bnd_so = 0; dr_so = '0; scan_so = '0; ir_so = 0;
        for (int c = 3 + NUM_DR; c < (1 << SEL_W); c++) begin
            path_sel = SEL_W'(c);
            #1;
            chk(so, 1'b1, "R9 unused code bypass");
        end
        @(negedge clk);
        path_sel = SEL_W'((1 << SEL_W) - 1);
        shift_en = 1;
        clock_bit(1'b0);
        chk(so, 1'b0, "R9 unused code shifts");
        shift_en = 0;
    endtask

    initial begin
        #1;
        chk(so, 1'b0, "R1 reset state");
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_bypass_shift();
        t_hold();
        t_ir();
        t_boundary();
        t_scan();
        t_dr();
        t_unused();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule